// File: doc/BRIEF.md
# Direct-Mapped Split Address Translation Cache

This block caches recent linear-to-physical page translations for a 32-bit core with 4 KB pages. Storage is divided into four direct-mapped arrays: one each for read and write accesses, and each of those is kept separately for user and supervisor privilege. A lookup is combinational. It presents a linear address, an access type and a privilege, and gets back a hit flag, the physical address and a flag that marks the target as I/O space rather than ordinary memory.

Translations are installed through a fill port after a page walk that sits outside this block. A fill always writes the read array for its privilege. It writes the write array only when the walk granted write permission. For a 4 MB page, only the 4 KB slice that holds the faulting address is installed.

Three inputs take entries away:
- Any change of the paging-enable level flushes every entry.
- A write of the page-directory base while paging is on flushes every entry.
- A single-page invalidate removes the matching page from all four arrays.

The fill port follows valid/ready rules. `fill_valid` is held, with stable fields, until a clock edge where `fill_ready` is high, and the fill is taken on that edge. `fill_ready` is low in any cycle where a flush or a page invalidate is being applied. Invalidation therefore always wins, and a held fill simply waits for the next cycle.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses (`lk_hit`=0, `lk_io`=0).
- R2: The set index is linear address bits [12 +: log2(ENTRIES)]. A hit needs a valid entry whose stored page number equals address bits 31:12. On a hit, `lk_paddr` = {stored frame, address bits 11:0}.
- R3: The lookup uses the array picked by (`lk_write`, `lk_user`). An entry filled for one privilege is not visible to the other privilege.
- R4: A taken fill always writes the read array of its privilege. It writes the write array of that privilege only when `fill_wr_ok`=1.
- R5: When `fill_large`=1, the stored frame is the upper 10 bits of `fill_pfn` followed by the low 10 bits of `fill_vpn`. Only that one 4 KB page hits; the neighbouring 4 KB page of the same large page misses.
- R6: The I/O flag given with a fill is returned on `lk_io` when that entry hits. `lk_io` is 0 on a miss.
- R7: A cycle in which `pg_en` differs from its value in the previous cycle invalidates all entries in all arrays at that clock edge.
- R8: `dir_base_wr`=1 while `pg_en`=1 invalidates all entries. While `pg_en`=0 it has no effect.
- R9: `inv_valid` with `inv_vpn` clears, in all four arrays, the entry at that page's index if its stored page equals `inv_vpn`. An entry at the same index with another page number is kept.
- R10: `fill_ready` is 0 in any cycle with a flush (R7, R8) or `inv_valid`=1, and 1 otherwise. A fill is taken at an edge with `fill_valid` and `fill_ready` both high, and it is visible to lookups from the next cycle.
- R11: A fill to an index that already holds another page replaces it, so the old page then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_addr | input | 32 | Lookup linear address |
| lk_write | input | 1 | Lookup is a write access |
| lk_user | input | 1 | Lookup is at user privilege |
| lk_hit | output | 1 | Lookup found a translation |
| lk_paddr | output | 32 | Translated physical address |
| lk_io | output | 1 | Hit entry targets I/O space |
| fill_valid | input | 1 | Fill request present |
| fill_ready | output | 1 | Fill can be taken this cycle |
| fill_vpn | input | 20 | Linear page number of the fill |
| fill_pfn | input | 20 | Physical frame number from the walk |
| fill_user | input | 1 | Fill targets user arrays |
| fill_wr_ok | input | 1 | Walk granted write permission |
| fill_large | input | 1 | Frame comes from a 4 MB page |
| fill_io | input | 1 | Frame is I/O space |
| pg_en | input | 1 | Paging-enable level |
| dir_base_wr | input | 1 | Page-directory base written this cycle |
| inv_valid | input | 1 | Single-page invalidate request |
| inv_vpn | input | 20 | Page number to invalidate |

## Verification
The assertions check on every cycle that:
- a full flush leaves no valid entry;
- a fill writes exactly the entry it carries;
- `fill_ready` is low whenever an invalidation is in flight;
- no lookup hits in the cycle after a paging-enable change.

Only the bench scenarios can show the rest. That covers:
- which array a fill reaches for each privilege and write permission;
- the frame stored for a large-page slice;
- that a page invalidate spares a different page at the same index;
- that a directory-base write is ignored while paging is off.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int unsigned XL_VA_W  = 32;
  localparam int unsigned XL_OFS_W = 12;
  localparam int unsigned XL_PN_W  = XL_VA_W - XL_OFS_W;

  typedef struct packed {
    logic               vld;
    logic [XL_PN_W-1:0] vpn;
    logic               io;   // kept beside the tag, in place of the unused offset bits
    logic [XL_PN_W-1:0] ppn;
  } xl_entry_t;
endpackage

// File: rtl/xlat_flush_ctl.sv
module xlat_flush_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic pg_en,
  input  logic dir_base_wr,
  output logic flush_all
);
  logic pg_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) pg_prev <= 1'b0;
    else        pg_prev <= pg_en;
  end

  assign flush_all = (pg_en ^ pg_prev) | (dir_base_wr & pg_en);
endmodule

// File: rtl/xlat_fill_fmt.sv
module xlat_fill_fmt
  import xlat_pkg::*;
#(
  parameter int unsigned LARGE_OFS_W = 22
) (
  input  logic [XL_PN_W-1:0] fill_vpn,
  input  logic [XL_PN_W-1:0] fill_pfn,
  input  logic               fill_large,
  input  logic               fill_io,
  output xl_entry_t          ent
);
  localparam int unsigned SLICE_W = LARGE_OFS_W - XL_OFS_W;
  localparam logic [XL_PN_W-1:0] SLICE_MASK = XL_PN_W'((64'd1 << SLICE_W) - 64'd1);

  logic [XL_PN_W-1:0] frame;

  always_comb begin
    if (fill_large) frame = (fill_pfn & ~SLICE_MASK) | (fill_vpn & SLICE_MASK);
    else            frame = fill_pfn;
    ent.vld = 1'b1;
    ent.vpn = fill_vpn;
    ent.io  = fill_io;
    ent.ppn = frame;
  end
endmodule

// File: rtl/xlat_bank.sv
module xlat_bank
  import xlat_pkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_all,
  input  logic               clr_pg,
  input  logic [XL_PN_W-1:0] clr_vpn,
  input  logic               wr_en,
  input  xl_entry_t          wr_ent,
  input  logic [IDX_W-1:0]   rd_idx,
  output xl_entry_t          rd_ent
);
  xl_entry_t          mem [ENTRIES];
  logic [ENTRIES-1:0] vld_vec;
  logic [IDX_W-1:0]   clr_idx;
  logic [IDX_W-1:0]   wr_idx;

  assign clr_idx = clr_vpn[IDX_W-1:0];
  assign wr_idx  = wr_ent.vpn[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < int'(ENTRIES); k++) mem[k] <= '0;
    end else if (clr_all) begin
      for (int k = 0; k < int'(ENTRIES); k++) mem[k].vld <= 1'b0;
    end else begin
      if (wr_en) mem[wr_idx] <= wr_ent;
      if (clr_pg && mem[clr_idx].vld && mem[clr_idx].vpn == clr_vpn)
        mem[clr_idx].vld <= 1'b0;
    end
  end

  always_comb begin
    for (int k = 0; k < int'(ENTRIES); k++) vld_vec[k] = mem[k].vld;
  end

  assign rd_ent = mem[rd_idx];

  // R7 R8
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (vld_vec == '0));

  // R4 R11
  write_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr_all && !clr_pg) |=> (mem[$past(wr_idx)] == $past(wr_ent)));
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int unsigned ENTRIES     = 16,
  parameter int unsigned LARGE_OFS_W = 22
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [XL_VA_W-1:0] lk_addr,
  input  logic               lk_write,
  input  logic               lk_user,
  output logic               lk_hit,
  output logic [XL_VA_W-1:0] lk_paddr,
  output logic               lk_io,
  input  logic               fill_valid,
  output logic               fill_ready,
  input  logic [XL_PN_W-1:0] fill_vpn,
  input  logic [XL_PN_W-1:0] fill_pfn,
  input  logic               fill_user,
  input  logic               fill_wr_ok,
  input  logic               fill_large,
  input  logic               fill_io,
  input  logic               pg_en,
  input  logic               dir_base_wr,
  input  logic               inv_valid,
  input  logic [XL_PN_W-1:0] inv_vpn
);
  localparam int unsigned IDX_W  = $clog2(ENTRIES);
  localparam int unsigned NBANKS = 4;   // index = {write, user}

  logic               flush_all;
  logic               fill_fire;
  xl_entry_t          fill_ent;
  xl_entry_t          rd_ents [NBANKS];
  xl_entry_t          sel_ent;
  logic [XL_PN_W-1:0] lk_vpn;

  xlat_flush_ctl u_flush (
    .clk         (clk),
    .rst_n       (rst_n),
    .pg_en       (pg_en),
    .dir_base_wr (dir_base_wr),
    .flush_all   (flush_all)
  );

  xlat_fill_fmt #(.LARGE_OFS_W(LARGE_OFS_W)) u_fmt (
    .fill_vpn   (fill_vpn),
    .fill_pfn   (fill_pfn),
    .fill_large (fill_large),
    .fill_io    (fill_io),
    .ent        (fill_ent)
  );

  assign fill_ready = !(flush_all || inv_valid);
  assign fill_fire  = fill_valid && fill_ready;
  assign lk_vpn     = lk_addr[XL_VA_W-1:XL_OFS_W];

  for (genvar g = 0; g < NBANKS; g++) begin : g_bank
    localparam bit IS_WR   = (g / 2) == 1;
    localparam bit IS_USER = (g % 2) == 1;
    logic bank_wr;
    assign bank_wr = fill_fire && (fill_user == IS_USER) && (!IS_WR || fill_wr_ok);

    xlat_bank #(.ENTRIES(ENTRIES)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_all (flush_all),
      .clr_pg  (inv_valid),
      .clr_vpn (inv_vpn),
      .wr_en   (bank_wr),
      .wr_ent  (fill_ent),
      .rd_idx  (lk_vpn[IDX_W-1:0]),
      .rd_ent  (rd_ents[g])
    );
  end

  always_comb begin
    sel_ent  = rd_ents[{lk_write, lk_user}];
    lk_hit   = sel_ent.vld && (sel_ent.vpn == lk_vpn);
    lk_io    = lk_hit && sel_ent.io;
    lk_paddr = {sel_ent.ppn, lk_addr[XL_OFS_W-1:0]};
  end

  // R10
  fill_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_ready) |-> !(inv_valid || flush_all));

  // R10
  inv_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> !fill_ready);

  // R7
  flush_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_en != $past(pg_en)) |=> !lk_hit);

  // R6
  io_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_io |-> lk_hit);
endmodule

// File: tb/sim_xlat_cache.sv
module sim_xlat_cache;
  localparam int CLK_P = 10;
  localparam int N     = 16;

  logic        clk = 0;
  logic        rst_n;
  logic [31:0] lk_addr;
  logic        lk_write, lk_user;
  logic        lk_hit, lk_io, fill_ready;
  logic [31:0] lk_paddr;
  logic        fill_valid, fill_user, fill_wr_ok, fill_large, fill_io;
  logic [19:0] fill_vpn, fill_pfn, inv_vpn;
  logic        pg_en, dir_base_wr, inv_valid;

  int n_chk = 0;
  int n_bad = 0;
  int cyc_n = 0;

  int          m_v   [4][N];
  logic [19:0] m_tag [4][N];
  logic [19:0] m_frm [4][N];
  logic        m_io  [4][N];
  logic        m_pgprev;

  always #(CLK_P/2) clk = ~clk;

  xlat_cache u0 (
    .clk(clk), .rst_n(rst_n),
    .lk_addr(lk_addr), .lk_write(lk_write), .lk_user(lk_user),
    .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_io(lk_io),
    .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_user(fill_user),
    .fill_wr_ok(fill_wr_ok), .fill_large(fill_large), .fill_io(fill_io),
    .pg_en(pg_en), .dir_base_wr(dir_base_wr),
    .inv_valid(inv_valid), .inv_vpn(inv_vpn)
  );

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", r, cyc_n, act, exp);
    end
  endtask

  // One cycle: compare outputs with the model, then advance the model at the edge.
  task automatic cyc(string r);
    logic flush, eh, ef;
    int b, i;
    #1;
    flush = (pg_en != m_pgprev) || (dir_base_wr && pg_en);
    ef = !(flush || inv_valid);
    b  = {30'd0, lk_write, lk_user};
    i  = int'(lk_addr[15:12]);
    eh = (m_v[b][i] != 0) && (m_tag[b][i] == lk_addr[31:12]);
    chk(r, {31'd0, lk_hit}, {31'd0, eh});
    chk(r, {31'd0, lk_io}, {31'd0, eh && m_io[b][i]});
    if (eh) chk(r, lk_paddr, {m_frm[b][i], lk_addr[11:0]});
    chk({r, " ready"}, {31'd0, fill_ready}, {31'd0, ef});
    @(posedge clk);
    if (flush) begin
      for (int bb = 0; bb < 4; bb++) for (int k = 0; k < N; k++) m_v[bb][k] = 0;
    end else if (inv_valid) begin
      for (int bb = 0; bb < 4; bb++) begin
        int k = int'(inv_vpn) % N;
        if (m_v[bb][k] != 0 && m_tag[bb][k] == inv_vpn) m_v[bb][k] = 0;
      end
    end else if (fill_valid) begin
      for (int bb = 0; bb < 4; bb++) begin
        if ((bb % 2) == int'(fill_user) && (bb < 2 || fill_wr_ok)) begin
          int k = int'(fill_vpn) % N;
          m_v[bb][k]   = 1;
          m_tag[bb][k] = fill_vpn;
          m_io[bb][k]  = fill_io;
          m_frm[bb][k] = fill_large ? ((fill_pfn & 20'hFFC00) | (fill_vpn & 20'h003FF))
                                    : fill_pfn;
        end
      end
    end
    m_pgprev = pg_en;
    @(negedge clk);
  endtask

  task automatic look(logic [31:0] a, logic w, logic u, string r);
    lk_addr = a; lk_write = w; lk_user = u;
    cyc(r);
  endtask

  task automatic do_fill(logic [19:0] vpn, logic [19:0] pfn, logic u, logic wok,
                         logic lg, logic io, string r);
    fill_vpn = vpn; fill_pfn = pfn; fill_user = u; fill_wr_ok = wok;
    fill_large = lg; fill_io = io; fill_valid = 1;
    cyc(r);
    fill_valid = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc_n++;
      if (cyc_n > 5000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected at most 5000", cyc_n);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    for (int bb = 0; bb < 4; bb++) for (int k = 0; k < N; k++) begin
      m_v[bb][k] = 0; m_tag[bb][k] = '0; m_frm[bb][k] = '0; m_io[bb][k] = 0;
    end
    m_pgprev = 0;
    rst_n = 0; lk_addr = 0; lk_write = 0; lk_user = 0;
    fill_valid = 0; fill_vpn = 0; fill_pfn = 0; fill_user = 0; fill_wr_ok = 0;
    fill_large = 0; fill_io = 0; pg_en = 0; dir_base_wr = 0; inv_valid = 0; inv_vpn = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: empty after reset, in every array
    look(32'h0000_5123, 0, 0, "R1");
    look(32'h0000_5123, 1, 1, "R1");
    look(32'h0000_0000, 0, 1, "R1");

    // R2 R4: user read-only fill
    do_fill(20'h12345, 20'h0ABCD, 1, 0, 0, 0, "R4");
    look(32'h1234_5678, 0, 1, "R2");
    look(32'h1234_5678, 1, 1, "R4");
    look(32'h1234_5678, 0, 0, "R3");

    // R3 R4: supervisor writable fill
    do_fill(20'h00007, 20'h11111, 0, 1, 0, 0, "R4");
    look(32'h0000_7ABC, 1, 0, "R4");
    look(32'h0000_7ABC, 0, 0, "R3");
    look(32'h0000_7ABC, 1, 1, "R3");

    // R11: same index, other page
    do_fill(20'h10007, 20'h22222, 0, 1, 0, 0, "R11");
    look(32'h0000_7ABC, 0, 0, "R11");
    look(32'h1000_7004, 1, 0, "R11");

    // R5: large page slice
    do_fill(20'h00403, 20'h3FC00, 1, 1, 1, 0, "R5");
    look(32'h0040_3ABC, 0, 1, "R5");
    look(32'h0040_4000, 0, 1, "R5");

    // R6: I/O flag
    do_fill(20'h0000A, 20'h0F00F, 0, 0, 0, 1, "R6");
    look(32'h0000_A010, 0, 0, "R6");
    look(32'h0000_A010, 1, 0, "R6");

    // R9: invalidate a different page at index 7, then the stored one
    inv_valid = 1; inv_vpn = 20'h00017; lk_addr = 32'h1000_7000; lk_write = 0; lk_user = 0;
    cyc("R9");
    inv_valid = 0;
    look(32'h1000_7000, 0, 0, "R9");
    inv_valid = 1; inv_vpn = 20'h10007;
    cyc("R9");
    inv_valid = 0;
    look(32'h1000_7000, 0, 0, "R9");
    look(32'h1000_7000, 1, 0, "R9");

    // R10: fill held while an invalidate is applied
    fill_vpn = 20'h00021; fill_pfn = 20'h04444; fill_user = 1; fill_wr_ok = 0;
    fill_large = 0; fill_io = 0; fill_valid = 1;
    inv_valid = 1; inv_vpn = 20'h00055; lk_addr = 32'h0002_1000; lk_write = 0; lk_user = 1;
    cyc("R10");
    inv_valid = 0;
    cyc("R10");
    fill_valid = 0;
    look(32'h0002_1FFF, 0, 1, "R10");

    // R8: directory base write with paging off is ignored
    dir_base_wr = 1; lk_addr = 32'h0000_A000; lk_write = 0; lk_user = 0;
    cyc("R8");
    dir_base_wr = 0;
    look(32'h0000_A000, 0, 0, "R8");

    // R7: paging turned on flushes
    pg_en = 1;
    cyc("R7");
    look(32'h0000_A000, 0, 0, "R7");
    look(32'h0002_1000, 0, 1, "R7");

    // R8: directory base write with paging on flushes
    do_fill(20'h00033, 20'h05555, 0, 1, 0, 0, "R8");
    look(32'h0003_3000, 0, 0, "R8");
    dir_base_wr = 1;
    cyc("R8");
    dir_base_wr = 0;
    look(32'h0003_3000, 0, 0, "R8");

    // R7: paging turned off flushes
    do_fill(20'h00033, 20'h05555, 0, 1, 0, 0, "R7");
    look(32'h0003_3000, 1, 0, "R7");
    pg_en = 0;
    cyc("R7");
    look(32'h0003_3000, 1, 0, "R7");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule